// File: doc/BRIEF.md
# Stereo Sticky Peak Level Meter

This block observes a stream of signed two's-complement stereo samples, taken ahead of any limiting stage, and grades each channel's sample magnitude into one of eight coarse level codes, from quieter than -6 dBFS up to clipping. Each channel keeps the loudest code seen since the last time its status was read. A lower level never pulls the stored code down.

The host sees an 8-bit status word. It holds both channel codes and two acceptance flags that logic outside this block supplies. A read strobe returns the current word in the same cycle and clears both stored codes on the following clock edge. A sample that is valid in the cycle of the read is not lost: its code becomes the new stored value.

Top module: `stereo_peak_meter`

## Requirements
- R1: After reset, and whenever reset is held low, both stored level codes are 000.
- R2: The status word is packed as follows. Bit 7 is the right acceptance flag and bit 6 is the left acceptance flag. Bits 5:3 hold the right level code and bits 2:0 hold the left level code. Both flags pass straight through from their inputs.
- R3: Level codes are set by the magnitude m relative to full scale FS = 2^(W-1)-1. Each threshold is floor(FS*f/65536), with f = 32845 (-6 dB), 36853 (-5 dB), 41350 (-4 dB), 46396 (-3 dB), 52057 (-2 dB) and 58409 (-1 dB). The code is 001 through 110 when m is at or above the -6 dB through -1 dB threshold, and 000 when m is below the -6 dB threshold. For W=24 these thresholds are 4204159, 4717183, 5292799, 5938687, 6663295 and 7476351.
- R4: Magnitude is the absolute value of the sample. A negative sample grades the same as its positive counterpart. A magnitude equal to FS gives code 111. The most negative sample saturates to FS and so gives 111.
- R5: A valid sample whose code is above the stored code replaces it. A sample whose code is lower or equal leaves the stored code unchanged.
- R6: In the cycle the read strobe is high, the status word still shows the stored codes. After that clock edge both codes are 000, provided no sample was valid in the same cycle.
- R7: When a read and a valid sample occur in the same cycle, each channel's stored code after the edge equals that sample's code.
- R8: Samples presented while the valid strobe is low have no effect on the stored codes.
- R9: The two channels are graded and held independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Both channel samples are valid this cycle |
| left_sample | input | SAMPLE_W | Left channel sample, two's complement |
| right_sample | input | SAMPLE_W | Right channel sample, two's complement |
| status_rd | input | 1 | Status read strobe; clears the stored codes |
| accept_left | input | 1 | Left acceptance flag from outside |
| accept_right | input | 1 | Right acceptance flag from outside |
| status_word | output | 8 | Packed flags and stored level codes |

## Verification
On every cycle, the assertions check four things: a stored code never falls on a plain sample, it stays still when no sample is valid, a read without a sample leaves zero, and a read with a sample captures exactly that sample's code. They also check that the most negative input ends in clipping. Only the bench's scenarios can show that the threshold boundaries sit where R3 places them, with a value one below each threshold giving the lower code. The same holds for the status bit packing, for the read returning the pre-clear value in its own cycle, and for the two channels staying independent.

// File: rtl/peak_meter_pkg.sv
package peak_meter_pkg;

    typedef logic [2:0] level_code_t;

    localparam int LEVEL_STEPS = 6;
    localparam int FRAC_BITS   = 16;
    localparam level_code_t CODE_QUIET = 3'd0;
    localparam level_code_t CODE_CLIP  = 3'd7;

    // Fractions of full scale in 1/65536 units, index 0 = -6 dB ... 5 = -1 dB.
    function automatic logic [63:0] step_fraction(input int idx);
        case (idx)
            0:       return 64'd32845;
            1:       return 64'd36853;
            2:       return 64'd41350;
            3:       return 64'd46396;
            4:       return 64'd52057;
            default: return 64'd58409;
        endcase
    endfunction

    function automatic logic [63:0] step_threshold(input int width, input int idx);
        logic [63:0] full;
        full = (64'd1 << (width - 1)) - 64'd1;
        return (full * step_fraction(idx)) >> FRAC_BITS;
    endfunction

endpackage

// File: rtl/level_classifier.sv
module level_classifier
    import peak_meter_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic [SAMPLE_W-1:0] sample,
    output level_code_t         code
);
    localparam int MAG_W = SAMPLE_W - 1;
    localparam logic [MAG_W-1:0] FULL_SCALE = {MAG_W{1'b1}};

    logic [SAMPLE_W-1:0]    abs_full;
    logic [MAG_W-1:0]       mag;
    logic [LEVEL_STEPS-1:0] hit;

    always_comb begin
        abs_full = sample[SAMPLE_W-1] ? ({SAMPLE_W{1'b0}} - sample) : sample;
        // only the most negative input leaves the top bit set: saturate it
        mag = abs_full[SAMPLE_W-1] ? FULL_SCALE : abs_full[MAG_W-1:0];
    end

    for (genvar g = 0; g < LEVEL_STEPS; g++) begin : g_step
        localparam logic [MAG_W-1:0] STEP_T = MAG_W'(step_threshold(SAMPLE_W, g));
        assign hit[g] = (mag >= STEP_T);
    end

    always_comb begin
        code = CODE_QUIET;
        for (int i = 0; i < LEVEL_STEPS; i++) begin
            if (hit[i]) code = level_code_t'(i + 1);
        end
        if (mag == FULL_SCALE) code = CODE_CLIP;
    end

endmodule

// File: rtl/peak_hold.sv
module peak_hold
    import peak_meter_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid,
    input  logic        clear,
    input  level_code_t code_in,
    output level_code_t peak
);
    typedef struct packed {
        level_code_t peak;
    } hold_state_t;

    hold_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d.peak = valid ? code_in : CODE_QUIET;
        end else if (valid && (code_in > state_q.peak)) begin
            state_d.peak = code_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign peak = state_q.peak;

    assert_no_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clear) |=> (peak >= $past(peak)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !clear) |=> $stable(peak));

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !valid) |=> (peak == CODE_QUIET));

    assert_read_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && valid) |=> (peak == $past(code_in)));

endmodule

// File: rtl/stereo_peak_meter.sv
module stereo_peak_meter
    import peak_meter_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] left_sample,
    input  logic [SAMPLE_W-1:0] right_sample,
    input  logic                status_rd,
    input  logic                accept_left,
    input  logic                accept_right,
    output logic [7:0]          status_word
);
    localparam int CHANNELS = 2;
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [SAMPLE_W-1:0] chan_sample [CHANNELS];
    level_code_t         chan_code   [CHANNELS];
    level_code_t         chan_peak   [CHANNELS];

    assign chan_sample[0] = left_sample;
    assign chan_sample[1] = right_sample;

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        level_classifier #(.SAMPLE_W(SAMPLE_W)) u_classify (
            .sample (chan_sample[c]),
            .code   (chan_code[c])
        );
        peak_hold u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid   (sample_valid),
            .clear   (status_rd),
            .code_in (chan_code[c]),
            .peak    (chan_peak[c])
        );
    end

    assign status_word = {accept_right, accept_left, chan_peak[1], chan_peak[0]};

    assert_min_clips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && left_sample == MOST_NEG) |=> (status_word[2:0] == CODE_CLIP));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (status_word[5:0] == 6'd0));

endmodule

// File: tb/stereo_peak_meter_bench.sv
module stereo_peak_meter_bench;
    localparam int W = 24;

    typedef struct packed {
        logic [W-1:0] l;
        logic [W-1:0] r;
        logic [2:0]   el;
        logic [2:0]   er;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{24'd0,          24'd0,          3'd0, 3'd0},
        '{24'd4204158,    24'd4204159,    3'd0, 3'd1},
        '{24'd4717183,    -24'sd4717183,  3'd2, 3'd2},
        '{24'd4717182,    24'd5292799,    3'd1, 3'd3},
        '{-24'sd5938687,  24'd5938686,    3'd4, 3'd3},
        '{24'd6663295,    24'd7476350,    3'd5, 3'd5},
        '{24'd7476351,    -24'sd7476351,  3'd6, 3'd6},
        '{24'd8388606,    24'd8388607,    3'd6, 3'd7},
        '{24'h800000,     -24'sd8388607,  3'd7, 3'd7},
        '{-24'sd1,        24'd1,          3'd0, 3'd0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sample_valid = 1'b0;
    logic [W-1:0] left_sample = '0;
    logic [W-1:0] right_sample = '0;
    logic         status_rd = 1'b0;
    logic         accept_left = 1'b0;
    logic         accept_right = 1'b0;
    logic [7:0]   status_word;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    stereo_peak_meter #(.SAMPLE_W(W)) u_stereo_peak_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .left_sample  (left_sample),
        .right_sample (right_sample),
        .status_rd    (status_rd),
        .accept_left  (accept_left),
        .accept_right (accept_right),
        .status_word  (status_word)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read();
        status_rd = 1'b1;
        step();
        status_rd = 1'b0;
    endtask

    task automatic put(input logic [W-1:0] l, input logic [W-1:0] r);
        left_sample  = l;
        right_sample = r;
        sample_valid = 1'b1;
        step();
        sample_valid = 1'b0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        left_sample = 24'd8388607;
        right_sample = 24'd8388607;
        sample_valid = 1'b1;
        step();
        chk("R1 held in reset", {2'b00, status_word[5:0]}, 8'h00);
        sample_valid = 1'b0;
        rst_n = 1'b1;
        step();
        chk("R1 after reset", status_word, 8'h00);

        // R2 R3 R4 R9: table of grades, flags and packing
        for (int i = 0; i < NV; i++) begin
            do_read();
            accept_left  = i[0];
            accept_right = i[1];
            put(VECS[i].l, VECS[i].r);
            chk("R3 R4 R9 grade", {2'b00, status_word[5:0]}, {2'b00, VECS[i].er, VECS[i].el});
            chk("R2 packing", status_word, {i[1], i[0], VECS[i].er, VECS[i].el});
        end
        accept_left = 1'b0;
        accept_right = 1'b0;

        // R5: sticky maximum
        do_read();
        put(24'd6663300, 24'd0);
        put(24'd4717200, 24'd0);
        chk("R5 lower keeps peak", status_word, 8'b00_000_101);
        put(24'd7476351, 24'd0);
        chk("R5 higher replaces", status_word, 8'b00_000_110);

        // R8: ignored without valid
        left_sample = 24'h800000;
        right_sample = 24'h7FFFFF;
        step();
        step();
        chk("R8 invalid ignored", status_word, 8'b00_000_110);

        // R6: read shows old value then clears
        status_rd = 1'b1;
        #1;
        chk("R6 read sees pre-clear", status_word, 8'b00_000_110);
        step();
        status_rd = 1'b0;
        chk("R6 cleared after read", status_word, 8'h00);

        // R7: read with sample captures the new sample only
        put(24'd8388607, 24'd8388607);
        chk("R7 setup", status_word, 8'b00_111_111);
        left_sample = 24'd4300000;
        right_sample = 24'd0;
        sample_valid = 1'b1;
        status_rd = 1'b1;
        step();
        sample_valid = 1'b0;
        status_rd = 1'b0;
        chk("R7 read plus sample", status_word, 8'b00_000_001);

        // R9: right channel alone
        do_read();
        put(24'd0, -24'sd5938690);
        chk("R9 right only", status_word, 8'b00_100_000);

        // R1: reset mid-run
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk("R1 reset clears", status_word, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule